// File: doc/BRIEF.md
# Synthesizer Serial Programming Interface

This block receives configuration words for a frequency synthesizer over a three-wire serial port made up of a serial clock, a data line and a load strobe. It resynchronizes all three wires into the system clock and shifts data in on each rising edge of the serial clock, most significant bit first, into a 24-bit shift register. A rising edge on the load strobe copies the word into one of four holding latches. The two least significant bits of the word choose the latch. The bits above them become the latch contents.

The control latch is decoded into named fields: prescaler choice, two charge-pump current settings, output and core power levels, mute-until-lock, pump gain, pump three-state, detector polarity, multiplexer select and counter reset. The other three latches are presented as raw payloads. A power-down controller uses the two mode bits of the control latch and an external chip-enable to produce a single power-down status. One mode takes effect at once. The other waits for a set number of rising edges of the reference divider output.

Top module: `synth_prog_if`

## Requirements
- R1: On each synchronized rising edge of `ser_clk`, the shift register moves left by one place and takes `ser_dat` into bit 0. After 24 clocks, the first bit sent is therefore in bit 23.
- R2: On a rising edge of `ser_load`, bits 1:0 of the shift register select a latch: 00 is control, 01 is reference counter, 10 is main counter and 11 is test. Bits 23:2 are copied into the selected latch, and the other three latches keep their contents.
- R3: The control latch bit positions are: prescaler 23:22, power-down mode 21:20 (bit 21 is the synchronous qualifier and bit 20 is the enable), current B 19:17, current A 16:14, output level 13:12, mute-until-lock 11, pump gain 10, pump three-state 9, detector polarity 8, mux select 7:5, counter reset 4 and core level 3:2.
- R4: After reset, every latch output is zero and `pd_active` is low while `chip_en` is high.
- R5: A control write with mode bits 21:20 equal to 01 sets `pd_active` on the clock edge that loads the latch.
- R6: A control write with mode bits 21:20 equal to 11 leaves `pd_active` unchanged through the first rising edge of `ref_div`. It sets `pd_active` one clock after the second rising edge.
- R7: A control write with bit 20 equal to 0 clears power-down on the load edge and cancels any pending synchronous power-down.
- R8: A low level on `chip_en` sets `pd_active` one clock later, whatever the mode bits hold. Raising `chip_en` again returns `pd_active` to the state the mode bits hold.
- R9: While `pd_active` is high, serial words are still shifted in and latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_load | input | 1 | Load strobe, asynchronous |
| chip_en | input | 1 | Chip enable; a low level forces power-down |
| ref_div | input | 1 | Reference divider output, synchronous to clk |
| presc_sel | output | 2 | Prescaler select |
| pd_mode | output | 2 | Power-down mode bits {sync, enable} |
| cp_cur_b | output | 3 | Charge pump current setting B |
| cp_cur_a | output | 3 | Charge pump current setting A |
| out_lvl | output | 2 | Output power level |
| mute_lock | output | 1 | Mute until lock |
| cp_gain | output | 1 | Charge pump gain |
| cp_tri | output | 1 | Charge pump three-state |
| pd_pol | output | 1 | Phase detector polarity |
| mux_sel | output | 3 | Output multiplexer select |
| cnt_rst | output | 1 | Counter reset |
| core_lvl | output | 2 | Core power level |
| rcnt_word | output | 22 | Reference counter latch payload |
| ncnt_word | output | 22 | Main counter latch payload |
| test_word | output | 22 | Test latch payload |
| pd_active | output | 1 | Power-down status |

## Verification
The hardest state to reach from the ports is a synchronous power-down that is armed but has not yet completed. In that state exactly one reference edge has been counted, and a new control write must either restart or cancel the count. The directed sequence loads the synchronous mode, gives a single `ref_div` pulse, checks that the status has not changed, and then gives the second pulse. A second sequence arms the mode again and cancels it with a normal-mode write before any pulses arrive. Random words with random latch selects, sent at serial speed, check the routing into the latches and the field decode.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'b00,
      SEL_RCNT = 2'b01,
      SEL_NCNT = 2'b10,
      SEL_TEST = 2'b11
   } latch_sel_e;

   localparam int CTRL_WORD_W = 24;
   localparam int SEL_BITS    = 2;
   localparam int NUM_LATCH   = 4;
   // synchronized input lanes
   localparam int LANE_CLK = 0;
   localparam int LANE_DAT = 1;
   localparam int LANE_LD  = 2;
   localparam int NUM_LANE = 3;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] lvl
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("sp_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else if (s == 0) chain[s] <= async_in;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign lvl = chain[STAGES-1];
endmodule

// File: rtl/sp_shift_latch.sv
module sp_shift_latch
   import synth_prog_pkg::*;
#(
   parameter int WORD_W = 24,
   parameter int SEL_W  = 2,
   localparam int PAY_W = WORD_W - SEL_W,
   localparam int NLAT  = 1 << SEL_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sclk_lvl,
   input  logic                  dat_lvl,
   input  logic                  ld_lvl,
   output logic [NLAT*PAY_W-1:0] lat_flat,
   output logic                  wr_ctrl,
   output logic [1:0]            wr_pd_bits
);
   generate
      if (WORD_W < 24 || SEL_W != 2) begin : g_bad
         $error("control layout needs a 24-bit word and a 2-bit select");
      end
   endgenerate

   logic              sclk_q, ld_q;
   logic              sclk_rise, ld_rise;
   logic [WORD_W-1:0] shreg;
   logic [SEL_W-1:0]  sel;
   logic [PAY_W-1:0]  lat_q [NLAT];

   assign sclk_rise = sclk_lvl & ~sclk_q;
   assign ld_rise   = ld_lvl & ~ld_q;
   assign sel       = shreg[SEL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         ld_q   <= 1'b0;
         shreg  <= '0;
      end else begin
         sclk_q <= sclk_lvl;
         ld_q   <= ld_lvl;
         if (sclk_rise) shreg <= {shreg[WORD_W-2:0], dat_lvl};
      end
   end

   // R1: left shift, newest bit at position 0
   a_r1_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sclk_rise) |-> (shreg[0] == $past(dat_lvl)) &&
                           (shreg[WORD_W-1:1] == $past(shreg[WORD_W-2:0])));

   generate
      for (genvar k = 0; k < NLAT; k++) begin : g_lat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lat_q[k] <= '0;
            else if (ld_rise && sel == SEL_W'(k)) lat_q[k] <= shreg[WORD_W-1:SEL_W];
         end
         assign lat_flat[k*PAY_W +: PAY_W] = lat_q[k];

         // R2: unselected latches hold
         a_r2_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_rise && sel != SEL_W'(k)) |=> $stable(lat_q[k]));
         // R2: selected latch takes the payload
         a_r2_selected_load: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_rise && sel == SEL_W'(k)) |=> lat_q[k] == $past(shreg[WORD_W-1:SEL_W]));
      end
   endgenerate

   assign wr_ctrl    = ld_rise && (sel == SEL_W'(SEL_CTRL));
   assign wr_pd_bits = shreg[21:20];
endmodule

// File: rtl/sp_pd_ctrl.sv
module sp_pd_ctrl #(
   parameter int REF_EDGES = 2,
   localparam int CNT_W    = (REF_EDGES < 2) ? 1 : $clog2(REF_EDGES)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_ctrl,
   input  logic [1:0] wr_pd_bits,
   input  logic       ref_div,
   input  logic       chip_en,
   output logic       pd_active
);
   generate
      if (REF_EDGES < 1) begin : g_bad
         $error("REF_EDGES must be at least one");
      end
   endgenerate

   logic             ref_q, ref_rise, ce_q, pd_state, armed;
   logic [CNT_W-1:0] cnt;
   logic             mode_en, mode_sync;

   assign ref_rise  = ref_div & ~ref_q;
   assign mode_en   = wr_pd_bits[0];
   assign mode_sync = wr_pd_bits[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q    <= 1'b0;
         ce_q     <= 1'b1;
         pd_state <= 1'b0;
         armed    <= 1'b0;
         cnt      <= '0;
      end else begin
         ref_q <= ref_div;
         ce_q  <= chip_en;
         if (wr_ctrl) begin
            cnt <= '0;
            if (!mode_en) begin
               pd_state <= 1'b0;
               armed    <= 1'b0;
            end else if (!mode_sync) begin
               pd_state <= 1'b1;
               armed    <= 1'b0;
            end else begin
               armed <= 1'b1;
            end
         end else if (armed && ref_rise) begin
            if (cnt == CNT_W'(REF_EDGES-1)) begin
               pd_state <= 1'b1;
               armed    <= 1'b0;
               cnt      <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign pd_active = ~ce_q | pd_state;

   // R5: immediate mode takes effect on the load edge
   a_r5_async_now: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wr_pd_bits == 2'b01) |=> pd_state);
   // R6: power-down only starts from an immediate write or a counted reference edge
   a_r6_sync_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_state) |-> $past(wr_ctrl || (armed && ref_rise)));
   // R7: normal-mode write clears and disarms
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wr_pd_bits[0]) |=> (!pd_state && !armed));
   // R8: low chip enable forces power-down
   a_r8_ce_force: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |=> pd_active);
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
   import synth_prog_pkg::*;
#(
   parameter int WORD_W      = 24,
   parameter int SEL_W       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int REF_EDGES   = 2,
   localparam int PAY_W      = WORD_W - SEL_W,
   localparam int NLAT       = 1 << SEL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_clk,
   input  logic             ser_dat,
   input  logic             ser_load,
   input  logic             chip_en,
   input  logic             ref_div,
   output logic [1:0]       presc_sel,
   output logic [1:0]       pd_mode,
   output logic [2:0]       cp_cur_b,
   output logic [2:0]       cp_cur_a,
   output logic [1:0]       out_lvl,
   output logic             mute_lock,
   output logic             cp_gain,
   output logic             cp_tri,
   output logic             pd_pol,
   output logic [2:0]       mux_sel,
   output logic             cnt_rst,
   output logic [1:0]       core_lvl,
   output logic [PAY_W-1:0] rcnt_word,
   output logic [PAY_W-1:0] ncnt_word,
   output logic [PAY_W-1:0] test_word,
   output logic             pd_active
);
   logic [NUM_LANE-1:0]   raw, lvl;
   logic [NLAT*PAY_W-1:0] lat_flat;
   logic [PAY_W-1:0]      ctrl_p;
   logic                  wr_ctrl;
   logic [1:0]            wr_pd_bits;

   assign raw[LANE_CLK] = ser_clk;
   assign raw[LANE_DAT] = ser_dat;
   assign raw[LANE_LD]  = ser_load;

   sp_sync #(.STAGES(SYNC_STAGES), .W(NUM_LANE)) i_sync (
      .clk(clk), .rst_n(rst_n), .async_in(raw), .lvl(lvl));

   sp_shift_latch #(.WORD_W(WORD_W), .SEL_W(SEL_W)) i_shl (
      .clk(clk), .rst_n(rst_n),
      .sclk_lvl(lvl[LANE_CLK]), .dat_lvl(lvl[LANE_DAT]), .ld_lvl(lvl[LANE_LD]),
      .lat_flat(lat_flat), .wr_ctrl(wr_ctrl), .wr_pd_bits(wr_pd_bits));

   sp_pd_ctrl #(.REF_EDGES(REF_EDGES)) i_pd (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_pd_bits(wr_pd_bits),
      .ref_div(ref_div), .chip_en(chip_en), .pd_active(pd_active));

   assign ctrl_p    = lat_flat[int'(SEL_CTRL)*PAY_W +: PAY_W];
   assign rcnt_word = lat_flat[int'(SEL_RCNT)*PAY_W +: PAY_W];
   assign ncnt_word = lat_flat[int'(SEL_NCNT)*PAY_W +: PAY_W];
   assign test_word = lat_flat[int'(SEL_TEST)*PAY_W +: PAY_W];

   // payload index = word bit - SEL_W
   assign presc_sel = ctrl_p[23-SEL_W:22-SEL_W];
   assign pd_mode   = ctrl_p[21-SEL_W:20-SEL_W];
   assign cp_cur_b  = ctrl_p[19-SEL_W:17-SEL_W];
   assign cp_cur_a  = ctrl_p[16-SEL_W:14-SEL_W];
   assign out_lvl   = ctrl_p[13-SEL_W:12-SEL_W];
   assign mute_lock = ctrl_p[11-SEL_W];
   assign cp_gain   = ctrl_p[10-SEL_W];
   assign cp_tri    = ctrl_p[9-SEL_W];
   assign pd_pol    = ctrl_p[8-SEL_W];
   assign mux_sel   = ctrl_p[7-SEL_W:5-SEL_W];
   assign cnt_rst   = ctrl_p[4-SEL_W];
   assign core_lvl  = ctrl_p[3-SEL_W:2-SEL_W];

   // R8: status reflects chip enable from the previous cycle
   a_r8_ce_port: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chip_en) |=> pd_active);
endmodule

// File: tb/test_synth_prog_if.sv
module test_synth_prog_if;
   logic clk = 0, rst_n = 0;
   logic ser_clk = 0, ser_dat = 0, ser_load = 0, chip_en = 1, ref_div = 0;
   logic [1:0] presc_sel, pd_mode, out_lvl, core_lvl;
   logic [2:0] cp_cur_b, cp_cur_a, mux_sel;
   logic mute_lock, cp_gain, cp_tri, pd_pol, cnt_rst, pd_active;
   logic [21:0] rcnt_word, ncnt_word, test_word;

   int checks = 0, failures = 0;
   bit done = 0;
   logic [21:0] m_lat [4];
   logic        m_pd;

   always #5 clk = ~clk;

   synth_prog_if i_synth_prog_if (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_load(ser_load), .chip_en(chip_en), .ref_div(ref_div),
      .presc_sel(presc_sel), .pd_mode(pd_mode), .cp_cur_b(cp_cur_b),
      .cp_cur_a(cp_cur_a), .out_lvl(out_lvl), .mute_lock(mute_lock),
      .cp_gain(cp_gain), .cp_tri(cp_tri), .pd_pol(pd_pol), .mux_sel(mux_sel),
      .cnt_rst(cnt_rst), .core_lvl(core_lvl), .rcnt_word(rcnt_word),
      .ncnt_word(ncnt_word), .test_word(test_word), .pd_active(pd_active));

   // expected control outputs packed back into word bit positions 23:2 (R3)
   function automatic logic [21:0] ctrl_from_ports();
      logic [23:0] w;
      w = '0;
      w[23:22] = presc_sel; w[21:20] = pd_mode; w[19:17] = cp_cur_b;
      w[16:14] = cp_cur_a;  w[13:12] = out_lvl; w[11] = mute_lock;
      w[10] = cp_gain; w[9] = cp_tri; w[8] = pd_pol; w[7:5] = mux_sel;
      w[4] = cnt_rst; w[3:2] = core_lvl;
      return w[23:2];
   endfunction

   function automatic logic pd_after_write(logic [23:0] w, logic prev);
      if (!w[20]) return 1'b0;
      if (!w[21]) return 1'b1;
      return prev;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_word(logic [23:0] w);
      for (int i = 23; i >= 0; i--) begin
         ser_dat = w[i];
         wait_clk(4);
         ser_clk = 1;
         wait_clk(4);
         ser_clk = 0;
      end
      wait_clk(4);
      ser_load = 1;
      wait_clk(4);
      ser_load = 0;
      wait_clk(6);
      m_lat[w[1:0]] = w[23:2];
      if (w[1:0] == 2'b00) m_pd = pd_after_write(w, m_pd);
   endtask

   task automatic ref_pulse();
      ref_div = 1;
      wait_clk(2);
      ref_div = 0;
      wait_clk(2);
   endtask

   task automatic check_latches(string req);
      check(req, {10'd0, ctrl_from_ports()}, {10'd0, m_lat[0]});
      check(req, {10'd0, rcnt_word}, {10'd0, m_lat[1]});
      check(req, {10'd0, ncnt_word}, {10'd0, m_lat[2]});
      check(req, {10'd0, test_word}, {10'd0, m_lat[3]});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [23:0] w;
      void'($urandom(32'h5eed_0017));
      for (int k = 0; k < 4; k++) m_lat[k] = '0;
      m_pd = 0;
      wait_clk(4);
      rst_n = 1;
      wait_clk(2);
      // R4: reset state
      check_latches("R4");
      check("R4", {31'd0, pd_active}, 32'd0);

      // R1/R3: distinct bit patterns into the control latch
      send_word(24'hAAAAA8);
      check_latches("R1");
      check("R5", {31'd0, pd_active}, {31'd0, m_pd});
      send_word(24'h000000 | 24'h5554_4 << 0);
      check_latches("R3");
      send_word(24'h800004 | 24'h000000);
      check_latches("R1");

      // R2: random words with random select
      for (int n = 0; n < 24; n++) begin
         w = $urandom;
         send_word(w);
         check_latches("R2");
         check("R3", {31'd0, pd_active}, {31'd0, m_pd});
      end

      // R7: normal mode write clears
      send_word(24'h000000);
      check("R7", {31'd0, pd_active}, 32'd0);
      // R5: immediate power-down
      send_word(24'h100000);
      check("R5", {31'd0, pd_active}, 32'd1);
      // R9: data still accepted during power-down
      send_word(24'h3C5A69);
      check("R9", {10'd0, rcnt_word}, {10'd0, 22'h0F169A});
      send_word(24'h123456);
      check("R9", {10'd0, ncnt_word}, {10'd0, m_lat[2]});
      check("R9", {31'd0, pd_active}, 32'd1);

      // R6: synchronous power-down after two reference edges
      send_word(24'h000000);
      send_word(24'h300000);
      check("R6", {31'd0, pd_active}, 32'd0);
      ref_pulse();
      check("R6", {31'd0, pd_active}, 32'd0);
      ref_pulse();
      check("R6", {31'd0, pd_active}, 32'd1);

      // R7: pending synchronous power-down cancelled
      send_word(24'h000000);
      send_word(24'h300000);
      ref_pulse();
      send_word(24'h200000);
      ref_pulse();
      ref_pulse();
      check("R7", {31'd0, pd_active}, 32'd0);
      // R6: a second write restarts the edge count
      send_word(24'h300000);
      ref_pulse();
      send_word(24'h300000);
      ref_pulse();
      check("R6", {31'd0, pd_active}, 32'd0);
      ref_pulse();
      check("R6", {31'd0, pd_active}, 32'd1);
      send_word(24'h000000);

      // R8: chip enable override
      chip_en = 0;
      wait_clk(1);
      check("R8", {31'd0, pd_active}, 32'd1);
      send_word(24'h0000C1);
      check("R8", {31'd0, pd_active}, 32'd1);
      check("R9", {10'd0, rcnt_word}, {10'd0, 22'h000030});
      chip_en = 1;
      wait_clk(2);
      check("R8", {31'd0, pd_active}, 32'd0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule